// File: doc/BRIEF.md
# Chained Interrupt Priority Resolver

This block picks which pending hardware interrupt a small processor core takes next. Eighteen maskable sources each own a byte-wide control register that holds a request bit and a 3-bit priority level. A request pulse from the source sets its request bit, and software can clear the bit. At each opcode-fetch strobe the block copies every request bit and level into a snapshot. It then holds that snapshot for a programmable number of cycles before it will take a new one. A serial chain of comparison stages walks the snapshot from source 0 to source 17. A stage replaces the winner passed down to it only when it is requesting and its level is strictly higher than that winner's. A tie therefore keeps the earlier source, and a level of 0 can never win.

The chain's winner is offered to the core only when its level is strictly above the current processor priority level (IPL) and the interrupt-disable flag is clear. Three fixed sources (reset, debug and watchdog) ignore both the flag and the IPL, and they outrank every maskable source. The block offers a vector on a valid/ready handshake. Once `irq_valid` rises, the vector and level stay frozen until the core raises `irq_ready`; the core may hold `irq_ready` low for any number of cycles. When valid and ready are both high, the block does three things: it sets the disable flag, it loads the IPL with the accepted level, and it clears the accepted request, both in the control register and in the snapshot. Software lowers the flag through the status-write port to allow a higher-level interrupt to nest.

Top module: `irq_prio_resolver`

## Requirements
- R1: Among snapshot sources with their request set, the one with the highest level is offered, with `irq_vector` = 3 + source index.
- R2: When requesting sources share the highest level, the source with the lower index wins.
- R3: A source with level 0 is never offered, even with its request set.
- R4: A maskable winner is offered only if its level is strictly greater than `ipl`; an equal level is not offered.
- R5: While `flag_i` is 1, no maskable source is offered.
- R6: Pending reset, debug and watchdog requests are offered regardless of `flag_i` and `ipl`, as vectors 0, 1 and 2, in that order of precedence, ahead of any maskable source.
- R7: On accept (`irq_valid` and `irq_ready` high at a clock edge), `flag_i` becomes 1 and `ipl` takes `irq_level`; the fixed sources use level 7. The accepted maskable source's request bit reads back 0.
- R8: While `irq_valid` is high and `irq_ready` is low, `irq_valid`, `irq_vector` and `irq_level` hold their values on the next cycle.
- R9: A fetch strobe takes a snapshot only when the hold counter is 0, and it then loads the counter from `hold_cycles`. A strobe that arrives while the counter is still counting down is ignored.
- R10: The register for source k is at byte address 0x6E + k. Its read value is {4'b0, request, level[2:0]}. A write sets the level from data bits 2:0; writing 0 to bit 3 clears the request, writing 1 to bit 3 leaves it unchanged, and a request pulse in the same cycle wins over the clear.
- R11: After reset all requests and levels are 0, `flag_i` is 1, `ipl` is 0 and `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| src_req | input | 18 | Per-source request set pulses |
| rst_req | input | 1 | Reset interrupt request pulse |
| dbg_req | input | 1 | Debug interrupt request pulse |
| wdt_req | input | 1 | Watchdog interrupt request pulse |
| fetch_strobe | input | 1 | Opcode-fetch sampling strobe |
| hold_cycles | input | 4 | Snapshot hold length in cycles |
| ps_we | input | 1 | Status write strobe for flag and IPL |
| ps_flag_i | input | 1 | Disable flag value to write |
| ps_ipl | input | 3 | IPL value to write |
| flag_i | output | 1 | Interrupt-disable flag |
| ipl | output | 3 | Current processor priority level |
| irq_valid | output | 1 | Vector offer valid |
| irq_ready | input | 1 | Core accepts the offer |
| irq_vector | output | 5 | Offered vector index |
| irq_level | output | 3 | Level of the offered vector |

## Verification
If the chain's tie rule or its comparison is wrong, the wrong vector shows on `irq_vector` one cycle after the status write that unmasks the snapshot. A missed request clear shows at once in the register read-back after the accept edge, and it shows again as a repeated offer. If the flag or IPL update is wrong, `flag_i` and `ipl` differ from their expected values on the cycle after the handshake. A hold counter that misses a strobe, or takes one it should ignore, makes a vector appear or fail to appear within two cycles of that strobe.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC     = 18;
  localparam int LVLW     = 3;
  localparam int NFIXED   = 3;
  localparam int VECW     = $clog2(NSRC + NFIXED);
  localparam int IDXW     = $clog2(NSRC);
  localparam logic [LVLW-1:0] FIXED_LVL = '1;

  typedef enum logic [1:0] {
    FX_RESET = 2'd0,
    FX_DEBUG = 2'd1,
    FX_WDOG  = 2'd2
  } fixed_vec_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NSRC = 18,
  parameter int LVLW = 3,
  parameter logic [7:0] BASE = 8'h6E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           bus_addr,
  input  logic                 bus_we,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NSRC-1:0]      set_pulse,
  input  logic [NSRC-1:0]      ack_clr,
  output logic [NSRC-1:0]      req_q,
  output logic [NSRC*LVLW-1:0] lvl_q
);
  logic [NSRC-1:0] sel;

  for (genvar k = 0; k < NSRC; k++) begin : g_reg
    assign sel[k] = (bus_addr == BASE + 8'(k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[k] <= 1'b0;
        lvl_q[k*LVLW +: LVLW] <= '0;
      end else begin
        if (set_pulse[k])
          req_q[k] <= 1'b1;
        else if (ack_clr[k] || (bus_we && sel[k] && !bus_wdata[3]))
          req_q[k] <= 1'b0;
        if (bus_we && sel[k])
          lvl_q[k*LVLW +: LVLW] <= bus_wdata[LVLW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NSRC; k++)
      if (sel[k])
        bus_rdata = {4'b0, req_q[k], lvl_q[k*LVLW +: LVLW]};
  end
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int NSRC  = 18,
  parameter int LVLW  = 3,
  parameter int HOLDW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_strobe,
  input  logic [HOLDW-1:0]     hold_cycles,
  input  logic [NSRC-1:0]      req_in,
  input  logic [NSRC*LVLW-1:0] lvl_in,
  input  logic [NSRC-1:0]      ack_clr,
  output logic [NSRC-1:0]      snap_req,
  output logic [NSRC*LVLW-1:0] snap_lvl
);
  logic [HOLDW-1:0] hold_cnt;
  logic             take;

  assign take = fetch_strobe && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      snap_req <= '0;
      snap_lvl <= '0;
    end else if (take) begin
      hold_cnt <= hold_cycles;
      snap_req <= req_in & ~ack_clr;
      snap_lvl <= lvl_in;
    end else begin
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      snap_req <= snap_req & ~ack_clr;
    end
  end
endmodule

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int NSRC = 18,
  parameter int LVLW = 3,
  parameter int IDXW = 5
) (
  input  logic [NSRC-1:0]      req,
  input  logic [NSRC*LVLW-1:0] lvl,
  output logic                 win_hit,
  output logic [IDXW-1:0]      win_idx,
  output logic [LVLW-1:0]      win_lvl
);
  logic [LVLW-1:0] pass_lvl [NSRC+1];
  logic [IDXW-1:0] pass_idx [NSRC+1];

  assign pass_lvl[0] = '0;
  assign pass_idx[0] = '0;

  for (genvar k = 0; k < NSRC; k++) begin : g_stage
    logic take_own;
    assign take_own      = req[k] && (lvl[k*LVLW +: LVLW] > pass_lvl[k]);
    assign pass_lvl[k+1] = take_own ? lvl[k*LVLW +: LVLW] : pass_lvl[k];
    assign pass_idx[k+1] = take_own ? IDXW'(k) : pass_idx[k];
  end

  assign win_hit = (pass_lvl[NSRC] != '0);
  assign win_idx = pass_idx[NSRC];
  assign win_lvl = pass_lvl[NSRC];
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int HOLDW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NSRC-1:0]   src_req,
  input  logic              rst_req,
  input  logic              dbg_req,
  input  logic              wdt_req,
  input  logic              fetch_strobe,
  input  logic [HOLDW-1:0]  hold_cycles,
  input  logic              ps_we,
  input  logic              ps_flag_i,
  input  logic [LVLW-1:0]   ps_ipl,
  output logic              flag_i,
  output logic [LVLW-1:0]   ipl,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VECW-1:0]   irq_vector,
  output logic [LVLW-1:0]   irq_level
);
  logic [NSRC-1:0]      req_q, snap_req, ack_clr;
  logic [NSRC*LVLW-1:0] lvl_q, snap_lvl;
  logic                 win_hit;
  logic [IDXW-1:0]      win_idx;
  logic [LVLW-1:0]      win_lvl;
  logic [NFIXED-1:0]    fx_pend;
  logic                 accept, mask_ok, fx_any;
  logic [VECW-1:0]      next_vec;
  logic [LVLW-1:0]      next_lvl;

  assign accept = irq_valid && irq_ready;

  always_comb begin
    ack_clr = '0;
    if (accept && irq_vector >= VECW'(NFIXED))
      ack_clr[irq_vector - VECW'(NFIXED)] = 1'b1;
  end

  irq_ctrl_regs #(.NSRC(NSRC), .LVLW(LVLW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_pulse(src_req),
    .ack_clr(ack_clr), .req_q(req_q), .lvl_q(lvl_q)
  );

  irq_sampler #(.NSRC(NSRC), .LVLW(LVLW), .HOLDW(HOLDW)) u_samp (
    .clk(clk), .rst_n(rst_n), .fetch_strobe(fetch_strobe),
    .hold_cycles(hold_cycles), .req_in(req_q), .lvl_in(lvl_q),
    .ack_clr(ack_clr), .snap_req(snap_req), .snap_lvl(snap_lvl)
  );

  irq_chain #(.NSRC(NSRC), .LVLW(LVLW), .IDXW(IDXW)) u_chain (
    .req(snap_req), .lvl(snap_lvl), .win_hit(win_hit),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // fixed-source pending flags: pulse sets, accept clears
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fx_pend <= '0;
    end else begin
      for (int f = 0; f < NFIXED; f++) begin
        if (accept && irq_vector == VECW'(f)) fx_pend[f] <= 1'b0;
      end
      if (rst_req) fx_pend[FX_RESET] <= 1'b1;
      if (dbg_req) fx_pend[FX_DEBUG] <= 1'b1;
      if (wdt_req) fx_pend[FX_WDOG]  <= 1'b1;
    end
  end

  assign fx_any  = |fx_pend;
  assign mask_ok = win_hit && (win_lvl > ipl) && !flag_i;

  always_comb begin
    next_vec = VECW'(NFIXED) + VECW'(win_idx);
    next_lvl = win_lvl;
    if (fx_any) begin
      next_lvl = FIXED_LVL;
      if (fx_pend[FX_RESET])      next_vec = VECW'(FX_RESET);
      else if (fx_pend[FX_DEBUG]) next_vec = VECW'(FX_DEBUG);
      else                        next_vec = VECW'(FX_WDOG);
    end
  end

  // offer register: frozen while valid and not ready
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
    end else if (accept) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && (fx_any || mask_ok)) begin
      irq_valid  <= 1'b1;
      irq_vector <= next_vec;
      irq_level  <= next_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_i <= 1'b1;
      ipl    <= '0;
    end else if (accept) begin
      flag_i <= 1'b1;
      ipl    <= irq_level;
    end else if (ps_we) begin
      flag_i <= ps_flag_i;
      ipl    <= ps_ipl;
    end
  end
endmodule

// File: rtl/irq_prio_resolver_checker.sv
module irq_prio_resolver_checker #(
  parameter int VECW = 5,
  parameter int LVLW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_valid,
  input logic            irq_ready,
  input logic [VECW-1:0] irq_vector,
  input logic [LVLW-1:0] irq_level,
  input logic            flag_i,
  input logic [LVLW-1:0] ipl
);
  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector) && $stable(irq_level));

  assert_accept_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready |=> flag_i && !irq_valid);

  assert_accept_loads_ipl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready |=> ipl == $past(irq_level));

  assert_masked_needs_clear_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && irq_vector >= VECW'(3) |-> !$past(flag_i));

  assert_masked_above_ipl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && irq_vector >= VECW'(3) |-> irq_level > $past(ipl));

  assert_fixed_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_vector < VECW'(3) |-> irq_level == '1);
endmodule

bind irq_prio_resolver irq_prio_resolver_checker #(
  .VECW(irq_prio_pkg::VECW), .LVLW(irq_prio_pkg::LVLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .irq_level(irq_level), .flag_i(flag_i), .ipl(ipl)
);

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
  localparam int N = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_we = 1'b0;
  logic [N-1:0] src_req = '0;
  logic        rst_req = 1'b0, dbg_req = 1'b0, wdt_req = 1'b0;
  logic        fetch_strobe = 1'b0;
  logic [3:0]  hold_cycles = '0;
  logic        ps_we = 1'b0, ps_flag_i = 1'b0;
  logic [2:0]  ps_ipl = '0;
  logic        flag_i, irq_valid, irq_ready = 1'b0;
  logic [2:0]  ipl, irq_level;
  logic [4:0]  irq_vector;

  int tests = 0, fails = 0, cycles = 0;
  logic [2:0] m_lvl [N];
  logic       m_req [N];

  always #4 clk = ~clk;

  irq_prio_resolver u_irq_prio_resolver (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int k, logic [7:0] d);
    bus_addr = 8'h6E + 8'(k); bus_wdata = d; bus_we = 1'b1; tick(); bus_we = 1'b0;
  endtask

  task automatic set_ps(logic f, logic [2:0] l);
    ps_we = 1'b1; ps_flag_i = f; ps_ipl = l; tick(); ps_we = 1'b0;
  endtask

  task automatic strobe(); fetch_strobe = 1'b1; tick(); fetch_strobe = 1'b0; endtask

  task automatic pulse(logic [N-1:0] m);
    src_req = m; tick(); src_req = '0;
    for (int k = 0; k < N; k++) if (m[k]) m_req[k] = 1'b1;
  endtask

  task automatic accept(); irq_ready = 1'b1; tick(); irq_ready = 1'b0; endtask

  // expected winner from the chain rule: -1 if none
  function automatic int exp_win(logic [2:0] cur_ipl);
    int best = -1; logic [2:0] bl = 0;
    for (int k = 0; k < N; k++)
      if (m_req[k] && m_lvl[k] > bl) begin bl = m_lvl[k]; best = k; end
    if (best >= 0 && bl <= cur_ipl) best = -1;
    return best;
  endfunction

  // clear all, program levels, masked strobe
  task automatic setup(logic [N-1:0] mask);
    set_ps(1'b1, 3'd0);
    for (int k = 0; k < N; k++) begin
      wr(k, {5'b0, m_lvl[k]}); m_req[k] = 1'b0;
    end
    pulse(mask);
    strobe();
  endtask

  task automatic run_case(string req, logic [2:0] cur_ipl);
    int w;
    set_ps(1'b0, cur_ipl);
    tick();
    w = exp_win(cur_ipl);
    chk(req, irq_valid, w >= 0);
    if (w >= 0) begin
      chk(req, irq_vector, 3 + w);
      chk("R7", irq_level, m_lvl[w]);
      accept();
      chk("R7 flag", flag_i, 1);
      chk("R7 ipl", ipl, m_lvl[w]);
      bus_addr = 8'h6E + 8'(w); #1;
      chk("R7 clear", bus_rdata[3], 0);
    end
  endtask

  initial begin
    tick(); tick(); rst_n = 1'b1; tick();
    chk("R11 flag", flag_i, 1);
    chk("R11 ipl", ipl, 0);
    chk("R11 valid", irq_valid, 0);
    bus_addr = 8'h70; #1; chk("R11 reg", bus_rdata, 0);

    // R10 register format and clear/set rules
    wr(3, 8'h05); pulse(18'h8);
    bus_addr = 8'h71; #1; chk("R10 read", bus_rdata, 8'h0D);
    wr(3, 8'h0E); bus_addr = 8'h71; #1; chk("R10 write1 keeps", bus_rdata, 8'h0E);
    bus_addr = 8'h71; bus_wdata = 8'h02; bus_we = 1'b1; src_req = 18'h8; tick();
    bus_we = 1'b0; src_req = '0; #1; chk("R10 set wins", bus_rdata, 8'h0A);
    wr(3, 8'h00); bus_addr = 8'h71; #1; chk("R10 clear", bus_rdata, 8'h00);

    // R2 tie keeps upstream
    for (int k = 0; k < N; k++) m_lvl[k] = 3'd1;
    m_lvl[2] = 3'd4; m_lvl[7] = 3'd4;
    setup(18'h84); run_case("R2", 3'd0);
    // R3 level 0 never wins
    for (int k = 0; k < N; k++) m_lvl[k] = 3'd0;
    setup(18'h3FFFF); run_case("R3", 3'd0);
    // R4 equal to IPL refused
    m_lvl[5] = 3'd3; setup(18'h20); run_case("R4 equal", 3'd3);
    setup(18'h20); run_case("R4 above", 3'd2);
    // R5 flag set blocks
    m_lvl[9] = 3'd7; setup(18'h200); tick(); tick();
    chk("R5", irq_valid, 0);

    // R6 fixed sources bypass flag; order reset>debug>wdt
    dbg_req = 1'b1; wdt_req = 1'b1; rst_req = 1'b1; tick();
    dbg_req = 1'b0; wdt_req = 1'b0; rst_req = 1'b0; tick();
    chk("R6 reset", irq_vector, 0); chk("R6 valid", irq_valid, 1);
    // R8 back-pressure: hold without ready
    tick(); tick(); tick();
    chk("R8 held", irq_valid, 1); chk("R8 vec", irq_vector, 0);
    accept(); chk("R7 fixed ipl", ipl, 7); tick();
    chk("R6 debug", irq_vector, 1); accept(); tick();
    chk("R6 wdog", irq_vector, 2); accept(); tick();
    chk("R6 drained", irq_valid, 0);

    // R9 hold window
    for (int k = 0; k < N; k++) m_lvl[k] = 3'd0;
    m_lvl[4] = 3'd6;
    setup(18'h0);
    set_ps(1'b0, 3'd0);
    hold_cycles = 4'd5; strobe();
    pulse(18'h10); strobe(); tick();
    chk("R9 ignored", irq_valid, 0);
    for (int i = 0; i < 6; i++) tick();
    strobe(); tick();
    chk("R9 sampled", irq_valid, 1); chk("R9 vec", irq_vector, 7);
    accept(); hold_cycles = 4'd0; for (int i = 0; i < 6; i++) tick();

    // R1 random
    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] m;
      for (int k = 0; k < N; k++) m_lvl[k] = 3'($urandom_range(0, 7));
      m = N'($urandom());
      setup(m);
      run_case("R1", 3'($urandom_range(0, 4)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule